// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of an integer ALU and the carry that a logical operation hands on to the flags. It is purely combinational. A 32-bit value goes in together with a shift kind, an 8-bit amount and the current carry flag. Out come the shifted value and the carry that the shift produced.

The shift kinds are logical left, logical right, arithmetic right and rotate right. Two input flags steer how an amount of zero is read. When the amount comes from an instruction field, a zero means a full-width shift for the two right shifts and a one-bit rotate through the carry for the rotate. When the amount comes from a register, a zero leaves the value alone. A separate immediate-operand mode builds an operand from the low byte of the value, rotated right by an even count.

The decode of these cases lives in a small control module. It passes a strobe struct to a datapath module, which holds the shift networks and a log-stage rotator.

Top module: `operand_shifter`

## Requirements
- R1: A shift whose amount is zero leaves `shiftResult` equal to `opValue` and `carryOut` equal to `carryIn`. This covers any zero amount taken from a register and a zero logical-left amount taken from a field.
- R2: Logical left (`shiftKind`=0) by n in 1..31 gives `opValue<<n`, and the carry is the last bit shifted out, bit 32-n. By 32 it gives 0 with carry equal to bit 0. Beyond 32 it gives 0 with carry 0.
- R3: With `amtFromReg`=0, a zero amount for logical right (`shiftKind`=1) or arithmetic right (`shiftKind`=2) is taken as a shift by 32.
- R4: Logical right by n in 1..31 gives `opValue>>n`, and the carry is bit n-1. By 32 it gives 0 with carry equal to bit 31. Beyond 32 it gives 0 with carry 0.
- R5: Arithmetic right by n in 1..31 fills the vacated bits with bit 31, and the carry is bit n-1. By 32 or more, every result bit equals bit 31 and so does the carry.
- R6: Rotate right (`shiftKind`=3) by a nonzero amount rotates by the amount modulo 32, and the carry equals bit 31 of the result. This holds for multiples of 32 too, where the value comes out unchanged.
- R7: With `amtFromReg`=0, a zero rotate amount shifts the value right by one and puts `carryIn` in bit 31. The carry is the old bit 0.
- R8: With `immMode`=1, the result is `opValue[7:0]` zero-extended and rotated right by twice `shiftAmt[3:0]`. `shiftKind`, `amtFromReg` and `shiftAmt[7:4]` have no effect in this mode. The carry is result bit 31 when `shiftAmt[3:0]` is nonzero and `carryIn` when it is zero.
- R9: A register-sourced amount uses all 8 bits, so every amount from 0 to 255 follows R2, R4, R5 and R6. A register-sourced amount never produces the one-bit rotate through carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opValue | input | 32 | Value to shift, or the byte source in immediate mode |
| shiftKind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| shiftAmt | input | 8 | Shift amount; low 4 bits are the half-rotation in immediate mode |
| amtFromReg | input | 1 | 1 when the amount was read from a register |
| immMode | input | 1 | 1 selects the rotated-immediate operand |
| carryIn | input | 1 | Current carry flag |
| shiftResult | output | 32 | Shifted or expanded operand |
| carryOut | output | 1 | Carry produced by the shifter |

## Verification
The immediate assertions inside the control and datapath modules are evaluated whenever the inputs change. They take for granted that every input holds a defined 0/1 value and that all inputs change together, so that no check looks at a mix of old and new operands. The stimulus respects both: the bench drives every input at the falling edge of its clock, all at once, and only with fully specified values. It covers the amounts 0, 1, 31, 32, 33 and 255, as well as random amounts across the whole 8-bit range.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  localparam int DATA_W = 32;
  localparam int AMT_W  = 8;
  localparam int IMM_W  = 8;
  localparam int ROT_W  = 4;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shiftKind_e;

  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_LSL,
    SEL_LSR,
    SEL_ASR,
    SEL_ROR,
    SEL_RRX,
    SEL_IMM
  } opSel_e;

  typedef struct packed {
    opSel_e            sel;
    logic [AMT_W-1:0]  amt;
    logic              keepCarry;
  } shiftCtrl_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int RW = ROT_W
) (
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             amtFromReg,
  input  logic             immMode,
  output shiftCtrl_t       ctrl
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DW);

  logic amtZero;
  assign amtZero = (amt == '0);

  always_comb begin
    ctrl.sel       = SEL_PASS;
    ctrl.amt       = amt;
    ctrl.keepCarry = 1'b0;
    if (immMode) begin
      ctrl.sel       = SEL_IMM;
      ctrl.amt       = AMT_W'({amt[RW-1:0], 1'b0});
      ctrl.keepCarry = (amt[RW-1:0] == '0);
    end else if (amtZero) begin
      if (amtFromReg) begin
        ctrl.sel       = SEL_PASS;
        ctrl.keepCarry = 1'b1;
      end else begin
        unique case (shiftKind_e'(kind))
          KIND_LSL: begin
            ctrl.sel       = SEL_PASS;
            ctrl.keepCarry = 1'b1;
          end
          KIND_LSR: begin
            ctrl.sel = SEL_LSR;
            ctrl.amt = FULL_AMT;
          end
          KIND_ASR: begin
            ctrl.sel = SEL_ASR;
            ctrl.amt = FULL_AMT;
          end
          default: ctrl.sel = SEL_RRX;
        endcase
      end
    end else begin
      unique case (shiftKind_e'(kind))
        KIND_LSL: ctrl.sel = SEL_LSL;
        KIND_LSR: ctrl.sel = SEL_LSR;
        KIND_ASR: ctrl.sel = SEL_ASR;
        default:  ctrl.sel = SEL_ROR;
      endcase
    end
  end

  // R3: a zero right-shift amount taken from a field reaches the datapath as a full-width shift
  always_comb begin
    if (!immMode && !amtFromReg && amtZero &&
        (kind == KIND_LSR || kind == KIND_ASR))
      a_r3_field_zero_is_full: assert (ctrl.amt == FULL_AMT);
  end

  // R9: a register-sourced amount never selects the one-bit rotate through carry
  always_comb begin
    if (!immMode && amtFromReg)
      a_r9_reg_never_rrx: assert (ctrl.sel != SEL_RRX);
  end

  // R8: the immediate rotation count is always even
  always_comb begin
    if (immMode)
      a_r8_imm_even_rotation: assert (ctrl.amt[0] == 1'b0 && ctrl.sel == SEL_IMM);
  end

endmodule

// File: rtl/bshift_rotr.sv
module bshift_rotr #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] rot,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = rot[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]} : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic [DW-1:0] value,
  input  logic          carryIn,
  input  shiftCtrl_t    ctrl,
  output logic [DW-1:0] result,
  output logic          carry
);

  localparam int SW = $clog2(DW);

  logic [DW:0]   lslExt;
  logic [DW:0]   lsrExt;
  logic [DW:0]   asrExt;
  logic [DW-1:0] rotIn;
  logic [DW-1:0] rotOut;

  assign lslExt = {1'b0, value} << ctrl.amt;
  assign lsrExt = {value, 1'b0} >> ctrl.amt;
  assign asrExt = $signed({value, 1'b0}) >>> ctrl.amt;
  assign rotIn  = (ctrl.sel == SEL_IMM) ? DW'(value[IW-1:0]) : value;

  bshift_rotr #(.W(DW), .SW(SW)) u_rotr (
    .din  (rotIn),
    .rot  (ctrl.amt[SW-1:0]),
    .dout (rotOut)
  );

  always_comb begin
    result = value;
    carry  = carryIn;
    unique case (ctrl.sel)
      SEL_LSL: begin
        result = lslExt[DW-1:0];
        carry  = lslExt[DW];
      end
      SEL_LSR: begin
        result = lsrExt[DW:1];
        carry  = lsrExt[0];
      end
      SEL_ASR: begin
        result = asrExt[DW:1];
        carry  = asrExt[0];
      end
      SEL_ROR: begin
        result = rotOut;
        carry  = rotOut[DW-1];
      end
      SEL_RRX: begin
        result = {carryIn, value[DW-1:1]};
        carry  = value[0];
      end
      SEL_IMM: begin
        result = rotOut;
        carry  = ctrl.keepCarry ? carryIn : rotOut[DW-1];
      end
      default: begin
        result = value;
        carry  = carryIn;
      end
    endcase
  end

  // R1: a kept-carry pass leaves value and carry intact
  always_comb begin
    if (ctrl.sel == SEL_PASS)
      a_r1_pass_unchanged: assert (result == value && carry == carryIn);
  end

  // R2: left shifts past the width clear both result and carry
  always_comb begin
    if (ctrl.sel == SEL_LSL && ctrl.amt > AMT_W'(DW))
      a_r2_lsl_beyond_width: assert (result == '0 && !carry);
  end

  // R4: a full-width logical right shift clears the value and returns the top bit
  always_comb begin
    if (ctrl.sel == SEL_LSR && ctrl.amt == AMT_W'(DW))
      a_r4_lsr_full_width: assert (result == '0 && carry == value[DW-1]);
  end

  // R5: arithmetic shifts of full width or more give a sign-filled word
  always_comb begin
    if (ctrl.sel == SEL_ASR && ctrl.amt >= AMT_W'(DW))
      a_r5_asr_sign_fill: assert ($countones(result) == (value[DW-1] ? DW : 0)
                                  && carry == value[DW-1]);
  end

  // R6: rotate carry follows the top result bit and preserves the bit count
  always_comb begin
    if (ctrl.sel == SEL_ROR)
      a_r6_ror_carry_top: assert (carry == result[DW-1] &&
                                  $countones(result) == $countones(value));
  end

  // R7: one-bit rotate through carry
  always_comb begin
    if (ctrl.sel == SEL_RRX)
      a_r7_rrx_bits: assert (result[DW-1] == carryIn && carry == value[0]);
  end

  // R8: the expanded immediate holds exactly the ones of the source byte
  always_comb begin
    if (ctrl.sel == SEL_IMM)
      a_r8_imm_bitcount: assert ($countones(result) == $countones(value[IW-1:0]));
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import bshift_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]    opValue,
  input  logic [1:0]       shiftKind,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             amtFromReg,
  input  logic             immMode,
  input  logic             carryIn,
  output logic [DW-1:0]    shiftResult,
  output logic             carryOut
);

  shiftCtrl_t ctrl;

  bshift_ctrl #(.DW(DW), .RW(ROT_W)) u_ctrl (
    .kind       (shiftKind),
    .amt        (shiftAmt),
    .amtFromReg (amtFromReg),
    .immMode    (immMode),
    .ctrl       (ctrl)
  );

  bshift_datapath #(.DW(DW), .IW(IMM_W)) u_dp (
    .value   (opValue),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .result  (shiftResult),
    .carry   (carryOut)
  );

endmodule

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opValue = '0;
  logic [1:0]  shiftKind = '0;
  logic [7:0]  shiftAmt = '0;
  logic        amtFromReg = 1'b0;
  logic        immMode = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] shiftResult;
  logic        carryOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #10 clk = ~clk;

  operand_shifter u_dut (
    .opValue     (opValue),
    .shiftKind   (shiftKind),
    .shiftAmt    (shiftAmt),
    .amtFromReg  (amtFromReg),
    .immMode     (immMode),
    .carryIn     (carryIn),
    .shiftResult (shiftResult),
    .carryOut    (carryOut)
  );

  // behavioural reference: bit-at-a-time shifting
  task automatic refModel(input logic [31:0] v, input logic [1:0] k, input logic [7:0] a,
                          input logic fromReg, input logic imm, input logic c,
                          output logic [31:0] r, output logic co, output string tag);
    int n;
    r = v; co = c; tag = "R1";
    if (imm) begin
      n = 2 * int'(a[3:0]);
      r = {24'd0, v[7:0]};
      for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
      if (n != 0) co = r[31];
      tag = "R8";
      return;
    end
    n = int'(a);
    if (n == 0 && !fromReg) begin
      if (k == 2'd1 || k == 2'd2) begin n = 32; tag = "R3"; end
      else if (k == 2'd3) begin
        co = v[0]; r = {c, v[31:1]}; tag = "R7";
        return;
      end
    end
    if (n == 0) return;
    case (k)
      2'd0: begin
        for (int i = 0; i < n; i++) begin co = r[31]; r = r << 1; end
        if (tag == "R1") tag = "R2";
      end
      2'd1: begin
        for (int i = 0; i < n; i++) begin co = r[0]; r = r >> 1; end
        if (tag == "R1") tag = "R4";
      end
      2'd2: begin
        for (int i = 0; i < n; i++) begin co = r[0]; r = {r[31], r[31:1]}; end
        if (tag == "R1") tag = "R5";
      end
      default: begin
        for (int i = 0; i < (n % 32); i++) r = {r[0], r[31:1]};
        co = r[31];
        tag = "R6";
      end
    endcase
    if (fromReg && n > 31) tag = {tag, "/R9"};
  endtask

  task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic [7:0] a,
                       input logic fromReg, input logic imm, input logic c);
    logic [31:0] er;
    logic        ec;
    string       tag;
    @(negedge clk);
    opValue = v; shiftKind = k; shiftAmt = a; amtFromReg = fromReg; immMode = imm; carryIn = c;
    refModel(v, k, a, fromReg, imm, c, er, ec, tag);
    @(posedge clk);
    #1;
    checkCount++;
    if (shiftResult !== er || carryOut !== ec) begin
      failCount++;
      $display("FAIL %s: v=%h k=%0d a=%0d reg=%0b imm=%0b c=%0b got %h/%0b expected %h/%0b",
               tag, v, k, a, fromReg, imm, c, shiftResult, carryOut, er, ec);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] amts [6];
    amts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give zero result and zero carry (R1)
    apply(32'h0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    // R1: zero amounts pass through with carry kept
    apply(32'hDEADBEEF, 2'd0, 8'd0, 1'b0, 1'b0, 1'b1);
    apply(32'h80000001, 2'd1, 8'd0, 1'b1, 1'b0, 1'b1);
    apply(32'h80000001, 2'd3, 8'd0, 1'b1, 1'b0, 1'b0);
    // R2 / R4 / R5 / R6 / R9 boundaries, both amount sources
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 6; i++)
        for (int s = 0; s < 2; s++) begin
          apply(32'h80000001, 2'(k), amts[i], 1'(s), 1'b0, 1'b0);
          apply(32'h7FFFFFFE, 2'(k), amts[i], 1'(s), 1'b0, 1'b1);
          apply(32'hC3A50F96, 2'(k), amts[i], 1'(s), 1'b0, 1'b1);
        end
    // R6: multiples of 32 leave the value unchanged
    apply(32'h12345678, 2'd3, 8'd64, 1'b1, 1'b0, 1'b0);
    apply(32'h92345678, 2'd3, 8'd96, 1'b1, 1'b0, 1'b0);
    // R3: field-zero right shifts are full width
    apply(32'h80000000, 2'd1, 8'd0, 1'b0, 1'b0, 1'b0);
    apply(32'h80000000, 2'd2, 8'd0, 1'b0, 1'b0, 1'b0);
    // R7: rotate through carry
    apply(32'h00000003, 2'd3, 8'd0, 1'b0, 1'b0, 1'b1);
    apply(32'h00000002, 2'd3, 8'd0, 1'b0, 1'b0, 1'b0);
    // R8: immediate expansion, upper bits and ignored inputs
    apply(32'hFFFFFF81, 2'd2, 8'hF0, 1'b1, 1'b1, 1'b1);
    apply(32'hFFFFFF81, 2'd1, 8'h01, 1'b0, 1'b1, 1'b0);
    apply(32'h000000FF, 2'd3, 8'hAF, 1'b0, 1'b1, 1'b0);
    apply(32'h00000002, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1);
    // random sweep over the full amount range
    for (int i = 0; i < 3000; i++)
      apply($urandom, 2'($urandom), 8'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom));
    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule